// File: doc/BRIEF.md
# Receive Character Queue with Fill-Level Interrupt

This block sits behind a UART receive shift register. Every time the shift register finishes a character it presents a one-cycle strobe with a 9-bit word. The block decides whether to keep the character. In 9-bit address-filtering mode it keeps only characters whose top bit is set. A kept character goes into a small first-in first-out queue, and the host drains the queue one character at a time.

A registered interrupt pulse tells the host when to come and read. Depending on a 2-bit mode it fires on every stored character, or only when a store brings the queue to three-quarters full or to completely full. When a character arrives and there is no room, the block raises a sticky overrun flag and stops storing. A host clear strobe drops the flag and empties the queue, so reception starts again from a clean state.

The inbound side is a plain strobe with no back-pressure. A shift register cannot hold a finished character, so it never waits. A character is either taken in the cycle its strobe is high or it is lost, and in that case the overrun flag records the loss. The host side is equally simple. The oldest character is always visible on the read data port, and a read strobe removes it.

Top module: `rx_char_queue`

## Requirements
- R1: The queue holds up to 4 characters and hands them out oldest first. `rd_data` always shows the oldest stored character, and a cycle with `rd_strobe` high removes that character at the clock edge.
- R2: `data_avail` is 1 exactly when at least one character is stored. It is 0 after reset and becomes 1 in the cycle after the first character is stored.
- R3: A character that passes the filter while 4 characters are already stored sets `overrun` at the next edge and is discarded. This holds even if `rd_strobe` is high in the same cycle. While `overrun` is 1, every arriving character is discarded, but reads continue to drain the queue.
- R4: `ovr_clear` clears `overrun` and empties the queue at the next edge. A character arriving in the same cycle is discarded.
- R5: With `irq_mode` 2'b00 or 2'b01, `rx_irq` is high for exactly one cycle, the cycle after each stored character.
- R6: With `irq_mode` 2'b10, `rx_irq` pulses only for a store that brings the count to 3. The count is taken as the count before the store plus one, and a same-cycle read does not change it.
- R7: With `irq_mode` 2'b11, `rx_irq` pulses only for a store that brings the count to 4, counted the same way as in R6.
- R8: With `nine_bit_en` = 1 and `addr_only_en` = 1, a character with bit 8 = 0 is discarded. It raises no interrupt and leaves `data_avail` unchanged. A character with bit 8 = 1 is stored with bit 8 kept.
- R9: With `nine_bit_en` = 0, `addr_only_en` has no effect. Every character is offered for storage, and its bit 8 is stored as 0.
- R10: While the queue is empty, `rd_data` is 0, and `rd_strobe` changes no state. The next character stored is the next one read.
- R11: After reset, `overrun` and `rx_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| chr_valid | input | 1 | One-cycle strobe: a finished character is on `chr_data` |
| chr_data | input | 9 | Finished character; bit 8 is the ninth (address) bit |
| nine_bit_en | input | 1 | 1 = 9-bit characters, 0 = 8-bit characters |
| addr_only_en | input | 1 | 1 = keep only characters with bit 8 set (9-bit mode only) |
| irq_mode | input | 2 | Interrupt threshold select (see R5 to R7) |
| rd_strobe | input | 1 | Host read: remove the oldest character |
| ovr_clear | input | 1 | Host strobe: clear overrun and empty the queue |
| rd_data | output | 9 | Oldest stored character, 0 when the queue is empty |
| data_avail | output | 1 | At least one character is stored |
| overrun | output | 1 | Sticky flag: a character was lost for lack of room |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |

## Verification
The assertions check the following on every cycle:
- a character that passes the filter and finds room makes `data_avail` high at the next edge;
- `overrun` stays set until it is cleared;
- a clear leaves both the flag and the queue empty;
- an interrupt pulse is always preceded by a character strobe;
- a filtered-out address character never produces an interrupt;
- an empty read shows zero.

Some behaviour involves counting stored characters, and only the bench's directed scenarios can show it. This covers first-in first-out ordering across several characters, the exact store that triggers the three-quarter and full interrupts, the discard of characters during overrun, and the clearing of bit 8 in 8-bit mode.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int CHAR_W = 9;

  typedef enum logic [1:0] {
    IRQ_EACH_A = 2'b00,
    IRQ_EACH_B = 2'b01,
    IRQ_3Q     = 2'b10,
    IRQ_FULL   = 2'b11
  } irq_mode_e;
endpackage

// File: rtl/rxq_admit.sv
// Decides whether an arriving character is stored, and owns the overrun flag.
module rxq_admit #(
  parameter int CHAR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chr_valid,
  input  logic [CHAR_W-1:0] chr_data,
  input  logic              nine_bit_en,
  input  logic              addr_only_en,
  input  logic              ovr_clear,
  input  logic              q_full,
  output logic              push,
  output logic [CHAR_W-1:0] push_data,
  output logic              overrun
);
  localparam int LOW_W = CHAR_W - 1;

  logic passes_filter;
  logic offered;
  logic lose_char;

  // Address filtering only applies in 9-bit mode.
  always_comb begin
    if (nine_bit_en && addr_only_en)
      passes_filter = chr_data[CHAR_W-1];
    else
      passes_filter = 1'b1;
  end

  assign offered   = chr_valid && passes_filter && !overrun && !ovr_clear;
  assign push      = offered && !q_full;
  assign lose_char = offered && q_full;

  // In 8-bit mode the ninth bit is not part of the character.
  assign push_data = {nine_bit_en & chr_data[CHAR_W-1], chr_data[LOW_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      overrun <= 1'b0;
    else if (ovr_clear)
      overrun <= 1'b0;
    else if (lose_char)
      overrun <= 1'b1;
  end
endmodule

// File: rtl/rxq_fifo.sv
// Small circular queue with flush and a combinational head view.
module rxq_fifo #(
  parameter int CHAR_W = 9,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [CHAR_W-1:0] din,
  input  logic              pop_req,
  input  logic              flush,
  output logic [CHAR_W-1:0] head,
  output logic              empty,
  output logic              full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CHAR_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [DEPTH-1:0]  slot_wr;
  logic              pop;

  assign empty = (count == '0);
  assign full  = (count == FULL_CNT);
  assign pop   = pop_req && !empty;
  assign head  = empty ? '0 : mem[rd_ptr];

  // Per-slot write enables.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign slot_wr[i] = push && (wr_ptr == PTR_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (slot_wr[i]) mem[i] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rxq_irq_gen.sv
// Turns a store event and the fill level it creates into an interrupt pulse.
module rxq_irq_gen
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  input  logic [1:0]                 irq_mode,
  output logic                       rx_irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int OCC_W = CNT_W + 1;
  localparam logic [OCC_W-1:0] LVL_3Q   = OCC_W'((DEPTH * 3) / 4);
  localparam logic [OCC_W-1:0] LVL_FULL = OCC_W'(DEPTH);

  logic [OCC_W-1:0] occ_after;
  logic             fire;

  // Fill level the store creates, ignoring a same-cycle read.
  assign occ_after = {1'b0, count} + 1'b1;

  always_comb begin
    fire = 1'b0;
    if (push) begin
      unique case (irq_mode_e'(irq_mode))
        IRQ_EACH_A, IRQ_EACH_B: fire = 1'b1;
        IRQ_3Q:                 fire = (occ_after == LVL_3Q);
        IRQ_FULL:               fire = (occ_after == LVL_FULL);
        default:                fire = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_irq <= 1'b0;
    else        rx_irq <= fire;
  end
endmodule

// File: rtl/rx_char_queue.sv
// Receive character queue: admission, storage and fill-level interrupt.
module rx_char_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chr_valid,
  input  logic [CHAR_W-1:0] chr_data,
  input  logic              nine_bit_en,
  input  logic              addr_only_en,
  input  logic [1:0]        irq_mode,
  input  logic              rd_strobe,
  input  logic              ovr_clear,
  output logic [CHAR_W-1:0] rd_data,
  output logic              data_avail,
  output logic              overrun,
  output logic              rx_irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              push;
  logic [CHAR_W-1:0] push_data;
  logic              q_empty, q_full;
  logic [CNT_W-1:0]  q_count;

  rxq_admit #(.CHAR_W(CHAR_W)) u_admit (
    .clk          (clk),
    .rst_n        (rst_n),
    .chr_valid    (chr_valid),
    .chr_data     (chr_data),
    .nine_bit_en  (nine_bit_en),
    .addr_only_en (addr_only_en),
    .ovr_clear    (ovr_clear),
    .q_full       (q_full),
    .push         (push),
    .push_data    (push_data),
    .overrun      (overrun)
  );

  rxq_fifo #(.CHAR_W(CHAR_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push),
    .din     (push_data),
    .pop_req (rd_strobe),
    .flush   (ovr_clear),
    .head    (rd_data),
    .empty   (q_empty),
    .full    (q_full),
    .count   (q_count)
  );

  rxq_irq_gen #(.DEPTH(DEPTH)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .count    (q_count),
    .irq_mode (irq_mode),
    .rx_irq   (rx_irq)
  );

  assign data_avail = !q_empty;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker
  import rxq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              chr_valid,
  input logic [CHAR_W-1:0] chr_data,
  input logic              nine_bit_en,
  input logic              addr_only_en,
  input logic              rd_strobe,
  input logic              ovr_clear,
  input logic [CHAR_W-1:0] rd_data,
  input logic              data_avail,
  input logic              overrun,
  input logic              rx_irq
);
  logic kept;
  assign kept = chr_valid && !(nine_bit_en && addr_only_en && !chr_data[CHAR_W-1]);

  // R2: a character that finds room makes data available
  p_avail_after_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    kept && !overrun && !ovr_clear && !rd_strobe |=> data_avail);

  // R3: overrun stays until cleared
  p_overrun_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !ovr_clear |=> overrun);

  // R4: clear empties the queue and drops the flag
  p_clear_flushes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_clear |=> !overrun && !data_avail);

  // R5: an interrupt pulse always follows a character strobe
  p_irq_needs_char_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> $past(chr_valid));

  // R8: a filtered-out address character raises no interrupt
  p_filtered_no_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chr_valid && nine_bit_en && addr_only_en && !chr_data[CHAR_W-1] |=> !rx_irq);

  // R10: empty queue shows zero
  p_empty_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !data_avail |-> rd_data == '0);
endmodule

bind rx_char_queue rxq_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .chr_valid    (chr_valid),
  .chr_data     (chr_data),
  .nine_bit_en  (nine_bit_en),
  .addr_only_en (addr_only_en),
  .rd_strobe    (rd_strobe),
  .ovr_clear    (ovr_clear),
  .rd_data      (rd_data),
  .data_avail   (data_avail),
  .overrun      (overrun),
  .rx_irq       (rx_irq)
);

// File: tb/rx_char_queue_test.sv
`timescale 1ns/1ps
module rx_char_queue_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chr_valid = 1'b0;
  logic [8:0] chr_data = '0;
  logic       nine_bit_en = 1'b1;
  logic       addr_only_en = 1'b0;
  logic [1:0] irq_mode = 2'b00;
  logic       rd_strobe = 1'b0;
  logic       ovr_clear = 1'b0;
  logic [8:0] rd_data;
  logic       data_avail, overrun, rx_irq;

  int checks = 0;
  int errors = 0;
  logic       last_irq;
  logic [8:0] got;

  always #2 clk = ~clk;

  rx_char_queue uut (
    .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
    .nine_bit_en(nine_bit_en), .addr_only_en(addr_only_en), .irq_mode(irq_mode),
    .rd_strobe(rd_strobe), .ovr_clear(ovr_clear), .rd_data(rd_data),
    .data_avail(data_avail), .overrun(overrun), .rx_irq(rx_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Offer one character; last_irq holds the pulse it produced.
  task automatic send(input logic [8:0] d);
    @(negedge clk);
    chr_valid = 1'b1;
    chr_data  = d;
    @(negedge clk);
    chr_valid = 1'b0;
    last_irq  = rx_irq;
  endtask

  // Read the oldest character (value seen before the pop).
  task automatic take(output logic [8:0] d);
    @(negedge clk);
    d = rd_data;
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic clear_all;
    @(negedge clk);
    ovr_clear = 1'b1;
    @(negedge clk);
    ovr_clear = 1'b0;
  endtask

  task automatic t_reset;
    chk("R2 reset data_avail", data_avail, 0);
    chk("R11 reset overrun", overrun, 0);
    chk("R11 reset rx_irq", rx_irq, 0);
  endtask

  task automatic t_order;
    irq_mode = 2'b00;
    send(9'h011); chk("R5 irq first", last_irq, 1);
    chk("R2 avail after store", data_avail, 1);
    send(9'h122); chk("R5 irq second", last_irq, 1);
    irq_mode = 2'b01;
    send(9'h033); chk("R5 irq mode 01", last_irq, 1);
    @(negedge clk); chk("R5 pulse one cycle", rx_irq, 0);
    take(got); chk("R1 oldest first", got, 9'h011);
    take(got); chk("R1 second", got, 9'h122);
    take(got); chk("R1 third", got, 9'h033);
    chk("R2 empty after reads", data_avail, 0);
  endtask

  task automatic t_empty_read;
    chk("R10 empty rd_data", rd_data, 0);
    take(got); chk("R10 empty read value", got, 0);
    chk("R10 still empty", data_avail, 0);
    send(9'h05A);
    take(got); chk("R10 next store read", got, 9'h05A);
  endtask

  task automatic t_mode_3q;
    irq_mode = 2'b10;
    send(9'h001); chk("R6 no irq at 1", last_irq, 0);
    send(9'h002); chk("R6 no irq at 2", last_irq, 0);
    send(9'h003); chk("R6 irq at 3", last_irq, 1);
    send(9'h004); chk("R6 no irq at 4", last_irq, 0);
    clear_all;
  endtask

  task automatic t_overrun;
    irq_mode = 2'b11;
    send(9'h0A1); send(9'h0A2); send(9'h0A3);
    chk("R7 no irq at 3", last_irq, 0);
    send(9'h0A4); chk("R7 irq at 4", last_irq, 1);
    chk("R3 no overrun when just full", overrun, 0);
    send(9'h0A5); chk("R3 overrun set", overrun, 1);
    chk("R3 no irq on lost char", last_irq, 0);
    take(got); chk("R3 read during overrun", got, 9'h0A1);
    send(9'h0A6);
    take(got); chk("R3 lost char discarded", got, 9'h0A2);
    take(got); chk("R3 order kept", got, 9'h0A3);
    chk("R3 overrun held", overrun, 1);
    // clear with a character arriving in the same cycle
    @(negedge clk);
    ovr_clear = 1'b1; chr_valid = 1'b1; chr_data = 9'h0B7;
    @(negedge clk);
    ovr_clear = 1'b0; chr_valid = 1'b0;
    chk("R4 overrun cleared", overrun, 0);
    chk("R4 queue flushed", data_avail, 0);
    send(9'h0C8);
    take(got); chk("R4 store after clear", got, 9'h0C8);
  endtask

  task automatic t_addr_filter;
    irq_mode = 2'b00;
    nine_bit_en = 1'b1; addr_only_en = 1'b1;
    send(9'h042); chk("R8 data char no irq", last_irq, 0);
    chk("R8 data char not stored", data_avail, 0);
    send(9'h143); chk("R8 address char irq", last_irq, 1);
    take(got); chk("R8 address char kept", got, 9'h143);
    addr_only_en = 1'b0;
  endtask

  task automatic t_eight_bit;
    nine_bit_en = 1'b0; addr_only_en = 1'b1;
    send(9'h055); chk("R9 filter ignored irq", last_irq, 1);
    send(9'h166);
    take(got); chk("R9 char kept", got, 9'h055);
    take(got); chk("R9 bit 8 cleared", got, 9'h066);
    nine_bit_en = 1'b1; addr_only_en = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_order;
    t_empty_read;
    t_mode_3q;
    t_overrun;
    t_addr_filter;
    t_eight_bit;
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule